// File: doc/BRIEF.md
# Debug Register File

This block holds the eight debug register numbers that a processor core exposes to its instruction decoder. Numbers 0 to 3 are breakpoint address registers, number 6 is the status register and number 7 is the control register. The decoder presents one indexed access per cycle, either a read or a write. Read data comes back combinationally in the same cycle, and writes take effect at the next rising clock edge.

Numbers 4 and 5 are legacy names. When the debug-extension input is low they act as 6 and 7. When that input is high, an access to them is rejected with an illegal-opcode fault pulse in the same cycle, and nothing is written. The status and control registers carry bits that always read as one. The block decodes the control register to raise an "I/O breakpoint armed" flag, which gates the port-I/O check path elsewhere in the core. When an address register is written while its slot is an enabled memory or instruction breakpoint, the block also emits a one-cycle re-arm strobe for that slot.

Top module: `dbg_regfile`

## Requirements
- R1: After reset, address registers 0 to 3 read 0x00000000, register 6 reads 0xFFFF0FF0 and register 7 reads 0x00000400.
- R2: A write to register 0, 1, 2 or 3 stores the data unchanged, and a later read of the same number returns it.
- R3: A write to register 6 stores the data OR 0xFFFF0FF0.
- R4: A write to register 7 stores the data OR 0x00000400.
- R5: While dbg_ext_i is low, numbers 4 and 5 read and write registers 6 and 7 respectively, with the same fixed-one bits applied.
- R6: While dbg_ext_i is high, a valid access to number 4 or 5 drives fault_o high in that same cycle and returns read data 0. The access changes no register.
- R7: fault_o is low in every cycle except the one described in R6.
- R8: io_armed_o is high exactly when some slot i (0 to 3) has control bits [17+4i:16+4i] equal to 2'b10 (I/O kind) and at least one of its enable bits 2i (local) and 2i+1 (global) set. The flag reflects a control write from the cycle after that write.
- R9: In the cycle of a write to address register i, rearm_o[i] is high when slot i is enabled and its kind field is not 2'b10. All other bits of rearm_o are low, and rearm_o is zero in cycles that are not such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access request this cycle |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_idx_i | input | 3 | Debug register number |
| acc_wdata_i | input | 32 | Write data |
| dbg_ext_i | input | 1 | Debug-extension control bit; when high, numbers 4 and 5 fault |
| rd_data_o | output | 32 | Combinational read data |
| fault_o | output | 1 | Illegal-opcode fault pulse |
| io_armed_o | output | 1 | Some enabled slot is of I/O kind |
| rearm_o | output | 4 | Per-slot re-arm strobe on an address write |

## Verification
The two functions that can land in the same cycle are the alias rejection and the control update. A write to number 5 is decoded both as a control write and as a candidate fault. The bench arms an I/O slot, then issues a write to number 5 that would disarm it, first with dbg_ext_i high and then with it low. With the input high, the bench expects fault_o in that cycle, an unchanged io_armed_o in the next cycle, and an unchanged control read-back. With the input low, it expects no fault, a cleared flag, and the written value OR 0x400.

// File: rtl/dbgrf_pkg.sv
package dbgrf_pkg;
  parameter int unsigned XLEN  = 32;
  parameter int unsigned NSLOT = 4;
  parameter int unsigned IDXW  = 3;

  localparam logic [XLEN-1:0] STAT_ONES = 32'hFFFF_0FF0;
  localparam logic [XLEN-1:0] CTRL_ONES = 32'h0000_0400;

  localparam int unsigned KIND_LSB    = 16;
  localparam int unsigned KIND_STRIDE = 4;

  localparam logic [IDXW-1:0] IDX_STAT  = 3'd6;
  localparam logic [IDXW-1:0] IDX_CTRL  = 3'd7;
  localparam logic [IDXW-1:0] IDX_ALS_S = 3'd4;
  localparam logic [IDXW-1:0] IDX_ALS_C = 3'd5;

  typedef enum logic [1:0] {
    BK_EXEC  = 2'b00,
    BK_WRITE = 2'b01,
    BK_IO    = 2'b10,
    BK_RDWR  = 2'b11
  } brk_kind_e;
endpackage

// File: rtl/dbgrf_decode.sv
module dbgrf_decode
  import dbgrf_pkg::*;
(
  input  logic            valid_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic            ext_i,
  output logic            fault_o,
  output logic            ok_o,
  output logic [IDXW-1:0] eff_idx_o
);
  logic is_alias;

  assign is_alias  = (idx_i == IDX_ALS_S) || (idx_i == IDX_ALS_C);
  assign fault_o   = valid_i && is_alias && ext_i;
  assign ok_o      = valid_i && !fault_o;
  // 4 -> 6, 5 -> 7
  assign eff_idx_o = is_alias ? idx_i + IDXW'(2) : idx_i;

  always_comb begin
    a_r7_fault_alias_only: assert (!fault_o || (valid_i && ext_i && idx_i inside {IDX_ALS_S, IDX_ALS_C}))
      else $error("fault outside alias access");
  end
endmodule

// File: rtl/dbgrf_slots.sv
module dbgrf_slots
  import dbgrf_pkg::*;
(
  input  logic [XLEN-1:0]  ctrl_i,
  output logic [NSLOT-1:0] live_mem_o,
  output logic             io_armed_o
);
  logic [NSLOT-1:0] io_hit;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic      en;
    brk_kind_e kind;
    assign en            = ctrl_i[2*i] | ctrl_i[2*i+1];
    assign kind          = brk_kind_e'(ctrl_i[KIND_LSB + KIND_STRIDE*i +: 2]);
    assign io_hit[i]     = en && (kind == BK_IO);
    assign live_mem_o[i] = en && (kind != BK_IO);
  end

  assign io_armed_o = |io_hit;
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
  import dbgrf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic             acc_we_i,
  input  logic [IDXW-1:0]  acc_idx_i,
  input  logic [XLEN-1:0]  acc_wdata_i,
  input  logic             dbg_ext_i,
  output logic [XLEN-1:0]  rd_data_o,
  output logic             fault_o,
  output logic             io_armed_o,
  output logic [NSLOT-1:0] rearm_o
);
  logic [XLEN-1:0]  addr_q [NSLOT];
  logic [XLEN-1:0]  stat_q, ctrl_q;
  logic             acc_ok;
  logic [IDXW-1:0]  eff_idx;
  logic [NSLOT-1:0] live_mem;
  logic             wr_en;

  dbgrf_decode u_dec (
    .valid_i   (acc_valid_i),
    .idx_i     (acc_idx_i),
    .ext_i     (dbg_ext_i),
    .fault_o   (fault_o),
    .ok_o      (acc_ok),
    .eff_idx_o (eff_idx)
  );

  dbgrf_slots u_slots (
    .ctrl_i     (ctrl_q),
    .live_mem_o (live_mem),
    .io_armed_o (io_armed_o)
  );

  assign wr_en = acc_ok && acc_we_i;

  for (genvar i = 0; i < NSLOT; i++) begin : g_addr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            addr_q[i] <= '0;
      else if (wr_en && eff_idx == IDXW'(i))  addr_q[i] <= acc_wdata_i;
    end
    assign rearm_o[i] = wr_en && (eff_idx == IDXW'(i)) && live_mem[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= STAT_ONES;
      ctrl_q <= CTRL_ONES;
    end else if (wr_en) begin
      if (eff_idx == IDX_STAT) stat_q <= acc_wdata_i | STAT_ONES;
      if (eff_idx == IDX_CTRL) ctrl_q <= acc_wdata_i | CTRL_ONES;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (acc_ok) begin
      if (eff_idx < IDXW'(NSLOT))  rd_data_o = addr_q[eff_idx[1:0]];
      else if (eff_idx == IDX_STAT) rd_data_o = stat_q;
      else if (eff_idx == IDX_CTRL) rd_data_o = ctrl_q;
    end
  end

  a_r3_stat_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & STAT_ONES) == STAT_ONES) else $error("status fixed ones lost");
  a_r4_ctrl_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & CTRL_ONES) == CTRL_ONES) else $error("control fixed ones lost");
  a_r6_fault_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> ($stable(stat_q) && $stable(ctrl_q))) else $error("faulted access changed state");
  a_r6_fault_zero_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> rd_data_o == '0) else $error("faulted access returned data");
  a_r9_rearm_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rearm_o)) else $error("multiple rearm strobes");
  a_r9_rearm_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rearm_o) |-> (acc_valid_i && acc_we_i && acc_idx_i < IDXW'(NSLOT))) else $error("rearm without address write");
  a_r8_armed_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[2*NSLOT-1:0] == '0) |-> !io_armed_o) else $error("armed with no slot enabled");
endmodule

// File: tb/tb_dbg_regfile.sv
module tb_dbg_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0, ext = 1'b0;
  logic [2:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        fault, armed;
  logic [3:0]  rearm;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] rd;
    bit          chk_rd;
    logic        fault;
    logic [3:0]  rearm;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  dbg_regfile dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_we_i(we),
    .acc_idx_i(idx), .acc_wdata_i(wdata), .dbg_ext_i(ext),
    .rd_data_o(rd_data), .fault_o(fault), .io_armed_o(armed), .rearm_o(rearm)
  );

  // monitor: samples mid-cycle, pops one expectation per access
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (sb.size() == 0) begin
        errors++; checks++;
        $display("FAIL scoreboard empty: act access idx=%0d exp none", idx);
      end else begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (fault !== e.fault) begin
          errors++; $display("FAIL %s fault act=%0b exp=%0b", e.tag, fault, e.fault);
        end
        checks++;
        if (rearm !== e.rearm) begin
          errors++; $display("FAIL %s rearm act=%b exp=%b", e.tag, rearm, e.rearm);
        end
        if (e.chk_rd) begin
          checks++;
          if (rd_data !== e.rd) begin
            errors++; $display("FAIL %s rd act=%h exp=%h", e.tag, rd_data, e.rd);
          end
        end
      end
    end
  end

  task automatic rd(input logic [2:0] i, input logic [31:0] exp_rd, input logic exp_f, input string tag);
    exp_t e;
    @(posedge clk); #1;
    valid = 1'b1; we = 1'b0; idx = i; wdata = '0;
    e.rd = exp_rd; e.chk_rd = 1'b1; e.fault = exp_f; e.rearm = 4'b0; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d, input logic exp_f,
                    input logic [3:0] exp_rearm, input string tag);
    exp_t e;
    @(posedge clk); #1;
    valid = 1'b1; we = 1'b1; idx = i; wdata = d;
    e.rd = '0; e.chk_rd = 1'b0; e.fault = exp_f; e.rearm = exp_rearm; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    valid = 1'b0; we = 1'b0;
  endtask

  task automatic chk_armed(input logic exp, input string tag);
    idle();
    @(negedge clk);
    checks++;
    if (armed !== exp) begin
      errors++; $display("FAIL %s io_armed act=%0b exp=%0b", tag, armed, exp);
    end
  endtask

  initial begin
    #100_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values, R5 alias reads
    rd(3'd0, 32'h0, 1'b0, "R1 addr0");
    rd(3'd3, 32'h0, 1'b0, "R1 addr3");
    rd(3'd6, 32'hFFFF0FF0, 1'b0, "R1 status");
    rd(3'd7, 32'h00000400, 1'b0, "R1 control");
    rd(3'd4, 32'hFFFF0FF0, 1'b0, "R5 read 4 as 6");
    rd(3'd5, 32'h00000400, 1'b0, "R5 read 5 as 7");
    chk_armed(1'b0, "R1 armed");

    // R2 address registers
    wr(3'd0, 32'h12345678, 1'b0, 4'b0, "R2 wr addr0");
    wr(3'd3, 32'hDEADBEEF, 1'b0, 4'b0, "R2 wr addr3");
    rd(3'd0, 32'h12345678, 1'b0, "R2 addr0");
    rd(3'd3, 32'hDEADBEEF, 1'b0, "R2 addr3");
    rd(3'd1, 32'h0, 1'b0, "R2 addr1 untouched");

    // R3 / R4 fixed ones
    wr(3'd6, 32'h0000000F, 1'b0, 4'b0, "R3 wr status");
    rd(3'd6, 32'hFFFF0FFF, 1'b0, "R3 status ones");
    wr(3'd6, 32'h0, 1'b0, 4'b0, "R3 wr status zero");
    rd(3'd6, 32'hFFFF0FF0, 1'b0, "R3 status zero");
    wr(3'd7, 32'h0, 1'b0, 4'b0, "R4 wr control zero");
    rd(3'd7, 32'h00000400, 1'b0, "R4 control zero");
    wr(3'd7, 32'h00000003, 1'b0, 4'b0, "R4 wr control");
    rd(3'd7, 32'h00000403, 1'b0, "R4 control");

    // R5 alias write
    wr(3'd4, 32'h00000001, 1'b0, 4'b0, "R5 wr 4");
    rd(3'd6, 32'hFFFF0FF1, 1'b0, "R5 status via 4");

    // R6 / R7 extension on
    idle(); ext = 1'b1;
    rd(3'd5, 32'h0, 1'b1, "R6 read 5 faults");
    wr(3'd5, 32'hFFFFFFFF, 1'b1, 4'b0, "R6 write 5 faults");
    wr(3'd4, 32'h0000F000, 1'b1, 4'b0, "R6 write 4 faults");
    rd(3'd7, 32'h00000403, 1'b0, "R6 control unchanged");
    rd(3'd6, 32'hFFFF0FF1, 1'b0, "R6 status unchanged");
    wr(3'd7, 32'h00000003, 1'b0, 4'b0, "R7 write 7 no fault");
    rd(3'd0, 32'h12345678, 1'b0, "R7 read 0 no fault");

    // R8 io armed flag
    wr(3'd7, 32'h00200008, 1'b0, 4'b0, "R8 slot1 io global");
    chk_armed(1'b1, "R8 slot1 io enabled");
    wr(3'd7, 32'h00200000, 1'b0, 4'b0, "R8 slot1 io disabled");
    chk_armed(1'b0, "R8 slot1 io disabled");
    wr(3'd7, 32'h20000040, 1'b0, 4'b0, "R8 slot3 io local");
    chk_armed(1'b1, "R8 slot3 io local");
    wr(3'd7, 32'h10000040, 1'b0, 4'b0, "R8 slot3 write kind");
    chk_armed(1'b0, "R8 slot3 non-io kind");
    wr(3'd7, 32'h20000040, 1'b0, 4'b0, "R8 rearm slot3 io");
    chk_armed(1'b1, "R8 armed again");

    // same cycle: alias write vs fault
    wr(3'd5, 32'h0, 1'b1, 4'b0, "R6 alias ctrl write rejected");
    chk_armed(1'b1, "R6 armed kept after fault");
    rd(3'd7, 32'h20000440, 1'b0, "R6 control kept");
    idle(); ext = 1'b0;
    wr(3'd5, 32'h0, 1'b0, 4'b0, "R5 alias ctrl write");
    chk_armed(1'b0, "R5 armed cleared via 5");
    rd(3'd7, 32'h00000400, 1'b0, "R5 control via 5");

    // R9 rearm strobe
    wr(3'd7, 32'h01200018, 1'b0, 4'b0, "R9 ctrl slot2 data slot1 io");
    wr(3'd2, 32'hA0A0A0A0, 1'b0, 4'b0100, "R9 rearm slot2");
    wr(3'd1, 32'hB0B0B0B0, 1'b0, 4'b0000, "R9 io slot no rearm");
    wr(3'd0, 32'hC0C0C0C0, 1'b0, 4'b0000, "R9 disabled slot no rearm");
    rd(3'd2, 32'hA0A0A0A0, 1'b0, "R9 read slot2 no rearm");
    wr(3'd7, 32'h00000001, 1'b0, 4'b0, "R9 ctrl slot0 exec local");
    wr(3'd0, 32'h00001000, 1'b0, 4'b0001, "R9 rearm slot0");
    idle(); ext = 1'b1;
    wr(3'd0, 32'h00002000, 1'b0, 4'b0001, "R9 rearm slot0 ext on");
    idle();
    idle();

    checks++;
    if (sb.size() != 0) begin
      errors++; $display("FAIL scoreboard leftover act=%0d exp=0", sb.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule